// File: doc/BRIEF.md
# DMA Move Address Guard

This block sits beside a DMA move engine and decides, for every move, whether the read-side (source) or write-side (destination) address may be used. The address map is divided into 32 fixed windows. Each window matches a constant upper-address pattern, and the boundary bit of each window is set at elaboration. Software opens a window by setting its bit in a 32-bit enable mask. All windows are closed after reset.

Four extension descriptors can each narrow one open window to a single equal-sized sub-range. A descriptor holds a 3-bit size code, a 5-bit slice selector and the index of the window it applies to. The size code sets how many address bits just below the window boundary form the sub-range index. Only indices that the 5-bit selector can name are reachable, so any index bits above bit 4 must be zero.

The decision is registered one cycle after the request. A blocked move produces a one-cycle interrupt pulse that says whether the failing move was a source or a destination access. Two sticky flags record the same distinction until software clears them by writing ones.

Top module: `dprot_guard`

## Requirements
- R1: After reset the enable mask is all zero, every descriptor is inactive and both sticky flags are zero, so the first request for any address is blocked.
- R2: Window i (0..31) matches when address bits 31 down to a_i equal i placed in bits 31:24 (upper bits zero), with a_i = 12 + 2*(i mod 4); an address one step above the window's top is not in that window.
- R3: An address in an enabled window that no active descriptor targets is allowed anywhere in that window.
- R4: An address whose window has its enable bit (bit i of the mask) at zero is blocked, whatever the descriptors say.
- R5: An address that lies in no window is blocked.
- R6: dec_valid is high in exactly the cycle after each cycle with req_valid high, and low otherwise; dec_allow is the decision for that request.
- R7: irq_pulse is high for one cycle exactly when dec_valid is high and dec_allow is low; irq_is_dst then equals the req_is_dst of that request.
- R8: Descriptor write data is {active[13], window[12:8], size[7:5], slice[4:0]}. For an active descriptor with size s, the index is address bits a-1 down to a-(7-s), and the address is allowed only if the low (7-s) bits of slice equal those index bits. A write takes effect for requests in later cycles.
- R9: With size 100b only slice[2:0] is compared, and slice[4:3] have no effect.
- R10: With size 000b the index is 7 bits wide, and its top two bits (address bits a-1 and a-2) must be zero for a match.
- R11: An inactive descriptor has no effect, and an active descriptor cannot open a window whose enable bit is zero.
- R12: Sticky flag bit 0 is set by a blocked source move and bit 1 by a blocked destination move. Writing a one to a bit through the clear port clears it, and a set in the same cycle wins over the clear.
- R13: When several active descriptors target one window, an address is allowed if it falls in the sub-range of any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Move address presented this cycle |
| req_addr | input | 32 | Move address |
| req_is_dst | input | 1 | 1 = destination (write) move, 0 = source (read) move |
| en_we | input | 1 | Write strobe for the window enable mask |
| en_wdata | input | 32 | New enable mask, bit i opens window i |
| ext_we | input | 1 | Write strobe for one extension descriptor |
| ext_sel | input | 2 | Descriptor being written |
| ext_wdata | input | 14 | Descriptor contents, layout in R8 |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for the sticky flags |
| sts_clr_data | input | 2 | Flags to clear |
| dec_valid | output | 1 | Decision valid, one cycle after the request |
| dec_allow | output | 1 | 1 = move allowed |
| irq_pulse | output | 1 | One-cycle protection interrupt |
| irq_is_dst | output | 1 | Interrupt is for a destination move |
| sts_flags | output | 2 | Sticky flags: bit 0 source, bit 1 destination |

## Verification
A blocked move can set a sticky flag in the same cycle that software writes a one to clear that flag. The bench sets up this collision by driving a violating request and the clear strobe at the same falling edge. After the next rising edge it expects the flag to read one, which shows the set won. It then repeats the clear alone and expects zero, and it checks that clearing one flag leaves the other flag set.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

    parameter int ADDR_W    = 32;
    parameter int NUM_WIN   = 32;
    parameter int NUM_EXT   = 4;
    parameter int SIZE_W    = 3;
    parameter int SLICE_W   = 5;
    parameter int BASE_LSB  = 12;
    parameter int LSB_STEP  = 2;
    parameter int LSB_KINDS = 4;

    localparam int WIN_IDX_W = $clog2(NUM_WIN);
    localparam int EXT_IDX_W = $clog2(NUM_EXT);
    localparam int SUB_W     = (1 << SIZE_W) - 1;
    localparam int DESC_W    = 1 + WIN_IDX_W + SIZE_W + SLICE_W;
    localparam int LOW_CUT   = BASE_LSB - SUB_W;

    typedef struct packed {
        logic                 active;
        logic [WIN_IDX_W-1:0] win;
        logic [SIZE_W-1:0]    size;
        logic [SLICE_W-1:0]   slice;
    } ext_desc_t;

    typedef logic [SUB_W-1:0] sub_fld_t;

    // boundary bit of window i
    function automatic int win_lsb(int i);
        return BASE_LSB + LSB_STEP * (i % LSB_KINDS);
    endfunction

    // constant upper pattern of window i
    function automatic logic [ADDR_W-1:0] win_base(int i);
        logic [ADDR_W-1:0] b;
        b = ADDR_W'(i);
        return b << (ADDR_W - 8);
    endfunction

    // sub-range match for one descriptor against the 7 bits below the boundary
    function automatic logic sub_hit(sub_fld_t fld, logic [SIZE_W-1:0] size,
                                     logic [SLICE_W-1:0] slice);
        sub_fld_t idx;
        sub_fld_t msk;
        idx = fld >> size;
        msk = SUB_W'((1 << (SUB_W - int'(size))) - 1);
        return (idx[SUB_W-1:SLICE_W] == '0) &&
               (((idx[SLICE_W-1:0] ^ slice) & msk[SLICE_W-1:0]) == '0);
    endfunction

endpackage

// File: rtl/dprot_cfg.sv
module dprot_cfg
    import dprot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_we,
    input  logic [NUM_WIN-1:0]   en_wdata,
    input  logic                 ext_we,
    input  logic [EXT_IDX_W-1:0] ext_sel,
    input  ext_desc_t            ext_wdata,
    output logic [NUM_WIN-1:0]   en_mask,
    output ext_desc_t            ext_tab [NUM_EXT]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask <= '0;
        end else if (en_we) begin
            en_mask <= en_wdata;
        end
    end

    for (genvar n = 0; n < NUM_EXT; n++) begin : g_desc
        always_ff @(posedge clk) begin
            if (rst) begin
                ext_tab[n] <= '0;
            end else if (ext_we && ext_sel == EXT_IDX_W'(n)) begin
                ext_tab[n] <= ext_wdata;
            end
        end
    end

endmodule

// File: rtl/dprot_window_match.sv
module dprot_window_match
    import dprot_pkg::*;
(
    input  logic [ADDR_W-1:0]              addr,
    output logic [NUM_WIN-1:0]             win_hit,
    output logic [NUM_WIN-1:0][SUB_W-1:0]  win_fld
);

    logic unused_low_bits;
    assign unused_low_bits = ^addr[LOW_CUT-1:0];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam int LSB = win_lsb(i);
        localparam logic [ADDR_W-1:0] BASE = win_base(i);
        assign win_hit[i] = (addr[ADDR_W-1:LSB] == BASE[ADDR_W-1:LSB]);
        assign win_fld[i] = addr[LSB-1 -: SUB_W];
    end

endmodule

// File: rtl/dprot_ext_filter.sv
module dprot_ext_filter
    import dprot_pkg::*;
(
    input  logic [NUM_WIN-1:0][SUB_W-1:0]  win_fld,
    input  ext_desc_t                      ext_tab [NUM_EXT],
    output logic [NUM_WIN-1:0]             covered,
    output logic [NUM_WIN-1:0]             sub_ok
);

    logic [NUM_EXT-1:0] ext_hit;

    for (genvar n = 0; n < NUM_EXT; n++) begin : g_ext
        sub_fld_t fld;
        assign fld        = win_fld[ext_tab[n].win];
        assign ext_hit[n] = sub_hit(fld, ext_tab[n].size, ext_tab[n].slice);
    end

    always_comb begin
        covered = '0;
        sub_ok  = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            for (int n = 0; n < NUM_EXT; n++) begin
                if (ext_tab[n].active && ext_tab[n].win == WIN_IDX_W'(w)) begin
                    covered[w] = 1'b1;
                    if (ext_hit[n]) begin
                        sub_ok[w] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dprot_status.sv
module dprot_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       viol,
    input  logic       viol_dst,
    input  logic       clr_we,
    input  logic [1:0] clr_data,
    output logic [1:0] flags
);

    logic [1:0] set_vec;
    logic [1:0] clr_vec;

    assign set_vec = {viol & viol_dst, viol & ~viol_dst};
    assign clr_vec = clr_we ? clr_data : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= 2'b00;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/dprot_guard.sv
module dprot_guard
    import dprot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_is_dst,
    input  logic                 en_we,
    input  logic [NUM_WIN-1:0]   en_wdata,
    input  logic                 ext_we,
    input  logic [EXT_IDX_W-1:0] ext_sel,
    input  logic [DESC_W-1:0]    ext_wdata,
    input  logic                 sts_clr_we,
    input  logic [1:0]           sts_clr_data,
    output logic                 dec_valid,
    output logic                 dec_allow,
    output logic                 irq_pulse,
    output logic                 irq_is_dst,
    output logic [1:0]           sts_flags
);

    logic [NUM_WIN-1:0]            en_mask;
    ext_desc_t                     ext_tab [NUM_EXT];
    logic [NUM_WIN-1:0]            win_hit;
    logic [NUM_WIN-1:0][SUB_W-1:0] win_fld;
    logic [NUM_WIN-1:0]            covered;
    logic [NUM_WIN-1:0]            sub_ok;
    logic                          allow_c;
    logic                          viol_c;

    dprot_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .ext_we    (ext_we),
        .ext_sel   (ext_sel),
        .ext_wdata (ext_desc_t'(ext_wdata)),
        .en_mask   (en_mask),
        .ext_tab   (ext_tab)
    );

    dprot_window_match u_match (
        .addr    (req_addr),
        .win_hit (win_hit),
        .win_fld (win_fld)
    );

    dprot_ext_filter u_filt (
        .win_fld (win_fld),
        .ext_tab (ext_tab),
        .covered (covered),
        .sub_ok  (sub_ok)
    );

    assign allow_c = |(win_hit & en_mask & (~covered | sub_ok));
    assign viol_c  = req_valid & ~allow_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_allow  <= 1'b0;
            irq_pulse  <= 1'b0;
            irq_is_dst <= 1'b0;
        end else begin
            dec_valid  <= req_valid;
            dec_allow  <= req_valid & allow_c;
            irq_pulse  <= viol_c;
            irq_is_dst <= viol_c & req_is_dst;
        end
    end

    dprot_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .viol     (viol_c),
        .viol_dst (req_is_dst),
        .clr_we   (sts_clr_we),
        .clr_data (sts_clr_data),
        .flags    (sts_flags)
    );

endmodule

// File: rtl/dprot_guard_chk.sv
module dprot_guard_chk
    import dprot_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_is_dst,
    input logic               sts_clr_we,
    input logic [1:0]         sts_clr_data,
    input logic               dec_valid,
    input logic               dec_allow,
    input logic               irq_pulse,
    input logic               irq_is_dst,
    input logic [1:0]         sts_flags,
    input logic [NUM_WIN-1:0] en_mask
);

    p_dec_follows_req_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_valid);

    p_no_spurious_dec_r6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !dec_valid);

    p_irq_on_block_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_allow) |-> irq_pulse);

    p_irq_only_on_block_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (dec_valid && !dec_allow));

    p_irq_dir_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!irq_pulse || irq_is_dst == $past(req_is_dst)));

    p_closed_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && en_mask == '0) |=> !dec_allow);

    p_sticky_src_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && !irq_is_dst) |-> sts_flags[0]);

    p_sticky_dst_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && irq_is_dst) |-> sts_flags[1]);

    p_sticky_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (sts_flags[0] && !(sts_clr_we && sts_clr_data[0])) |=> sts_flags[0]);

endmodule

bind dprot_guard dprot_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_dst   (req_is_dst),
    .sts_clr_we   (sts_clr_we),
    .sts_clr_data (sts_clr_data),
    .dec_valid    (dec_valid),
    .dec_allow    (dec_allow),
    .irq_pulse    (irq_pulse),
    .irq_is_dst   (irq_is_dst),
    .sts_flags    (sts_flags),
    .en_mask      (en_mask)
);

// File: tb/test_dprot_guard.sv
module test_dprot_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_dst = 1'b0;
    logic        en_we = 1'b0;
    logic [31:0] en_wdata = '0;
    logic        ext_we = 1'b0;
    logic [1:0]  ext_sel = '0;
    logic [13:0] ext_wdata = '0;
    logic        sts_clr_we = 1'b0;
    logic [1:0]  sts_clr_data = '0;
    logic        dec_valid;
    logic        dec_allow;
    logic        irq_pulse;
    logic        irq_is_dst;
    logic [1:0]  sts_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dprot_guard i_dprot_guard (
        .clk, .rst, .req_valid, .req_addr, .req_is_dst,
        .en_we, .en_wdata, .ext_we, .ext_sel, .ext_wdata,
        .sts_clr_we, .sts_clr_data,
        .dec_valid, .dec_allow, .irq_pulse, .irq_is_dst, .sts_flags
    );

    // {addr, is_dst, expected allow}
    localparam int NV = 20;
    localparam logic [33:0] VEC [NV] = '{
        {32'h0000_0000, 1'b0, 1'b1},  // R3 whole window 0
        {32'h0000_0FFC, 1'b1, 1'b1},  // R2 top of window 0
        {32'h0000_1000, 1'b0, 1'b0},  // R2 just above window 0
        {32'h0300_0000, 1'b1, 1'b0},  // R4 window 3 closed
        {32'h4000_0000, 1'b0, 1'b0},  // R5 no window
        {32'h0100_1000, 1'b0, 1'b1},  // R8 R9 sub-range 2
        {32'h0100_17FC, 1'b1, 1'b1},  // R9 end of sub-range 2
        {32'h0100_1800, 1'b0, 1'b0},  // R8 sub-range 3
        {32'h0100_0000, 1'b1, 1'b0},  // R8 sub-range 0
        {32'h0200_1200, 1'b1, 1'b1},  // R10 index 9
        {32'h0200_13FC, 1'b0, 1'b1},  // R10 end of index 9
        {32'h0200_1400, 1'b0, 1'b0},  // R10 index 10
        {32'h0200_9200, 1'b1, 1'b0},  // R10 bit a-1 set
        {32'h0200_5200, 1'b0, 1'b0},  // R10 bit a-2 set
        {32'h0500_0800, 1'b0, 1'b1},  // R13 first descriptor
        {32'h0500_3000, 1'b1, 1'b1},  // R13 second descriptor
        {32'h0500_1000, 1'b0, 1'b0},  // R13 neither
        {32'h0703_FFFC, 1'b1, 1'b1},  // R2 top of window 7
        {32'h0704_0000, 1'b1, 1'b0},  // R2 above window 7
        {32'h0400_0FFC, 1'b0, 1'b1}   // R3 window 4
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request, decision checked one cycle later
    task automatic probe(string req, logic [31:0] a, logic d, logic exp);
        req_valid  = 1'b1;
        req_addr   = a;
        req_is_dst = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " dec_valid"}, 32'(dec_valid), 32'd1);
        check({req, " dec_allow"}, 32'(dec_allow), 32'(exp));
        check({req, " irq_pulse"}, 32'(irq_pulse), 32'(!exp));
        if (!exp) check({req, " irq_is_dst"}, 32'(irq_is_dst), 32'(d));
    endtask

    task automatic wr_ext(logic [1:0] s, logic [13:0] v);
        ext_we = 1'b1; ext_sel = s; ext_wdata = v;
        @(posedge clk); @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic clr_sts(logic [1:0] m);
        sts_clr_we = 1'b1; sts_clr_data = m;
        @(posedge clk); @(negedge clk);
        sts_clr_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 dec_valid", 32'(dec_valid), 32'd0);
        check("R1 irq_pulse", 32'(irq_pulse), 32'd0);
        check("R1 sts_flags", 32'(sts_flags), 32'd0);
        probe("R1 closed after reset", 32'h0000_0000, 1'b0, 1'b0);
        check("R1 R12 src flag", 32'(sts_flags), 32'd1);
        clr_sts(2'b01);
        check("R12 cleared", 32'(sts_flags), 32'd0);

        // configuration
        en_we = 1'b1; en_wdata = 32'h0000_00F7;
        @(posedge clk); @(negedge clk);
        en_we = 1'b0;
        wr_ext(2'd0, {1'b1, 5'd1, 3'd4, 5'b11010});
        wr_ext(2'd1, {1'b1, 5'd2, 3'd0, 5'd9});
        wr_ext(2'd2, {1'b1, 5'd5, 3'd4, 5'd1});
        wr_ext(2'd3, {1'b1, 5'd5, 3'd4, 5'd6});

        for (int k = 0; k < NV; k++) begin
            probe($sformatf("vector %0d R2..R13", k), VEC[k][33:2], VEC[k][1], VEC[k][0]);
        end
        @(posedge clk); @(negedge clk);
        check("R6 no request no decision", 32'(dec_valid), 32'd0);
        check("R12 both flags from table", 32'(sts_flags), 32'd3);

        // R12 clear and set/clear collision
        clr_sts(2'b11);
        check("R12 clear both", 32'(sts_flags), 32'd0);
        sts_clr_we = 1'b1; sts_clr_data = 2'b01;
        probe("R12 collision src", 32'h4000_0000, 1'b0, 1'b0);
        sts_clr_we = 1'b0;
        check("R12 set wins src", 32'(sts_flags), 32'd1);
        sts_clr_we = 1'b1; sts_clr_data = 2'b10;
        probe("R12 collision dst", 32'h4000_0000, 1'b1, 1'b0);
        sts_clr_we = 1'b0;
        check("R12 set wins dst", 32'(sts_flags), 32'd3);
        clr_sts(2'b01);
        check("R12 clear one keeps other", 32'(sts_flags), 32'd2);

        // R11 inactive descriptor, descriptor on closed window
        wr_ext(2'd0, {1'b0, 5'd0, 3'd4, 5'd7});
        probe("R11 inactive descriptor", 32'h0000_0000, 1'b0, 1'b1);
        probe("R3 window 1 no longer narrowed", 32'h0100_0000, 1'b0, 1'b1);
        wr_ext(2'd0, {1'b1, 5'd3, 3'd7, 5'd0});
        probe("R11 descriptor cannot open closed window", 32'h0300_0000, 1'b1, 1'b0);

        // R4 mask closed again
        en_we = 1'b1; en_wdata = 32'h0;
        @(posedge clk); @(negedge clk);
        en_we = 1'b0;
        probe("R4 mask cleared", 32'h0000_0000, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule